// File: doc/BRIEF.md
# Stack and Call/Return Sequencer

This unit owns the stack pointer of a 16-bit processor that addresses memory in 16-bit words. It turns four stack commands into accesses on a single-port word memory: pushing a data word, popping a word, calling a subroutine and returning from one. A call saves the return address on the stack and then redirects the program counter to the target. A return pops the saved word straight into the program counter. The stack grows toward lower addresses. A push first moves the pointer down and then writes the new pointer location. A pop reads the current pointer location and then moves the pointer up.

The surrounding core presents exactly one command bit at a time while `cmd_ready` is high. It receives a `done` pulse when the command is complete. For a pop or a return, the fetched word is valid in the same cycle as `done`. For a call or a return, the new program counter is valid in that cycle and is marked by `pc_load`. The memory is external and returns read data one cycle after it sees a read request. The stack pointer is always visible on `sp_out`, so that the register file can show it as its stack-pointer entry. The unit leaves every other register alone, including the stack-base register.

Top module: `stack_call_unit`

## Requirements
- R1: While reset is held and in the first cycle after reset, `sp_out` is 0xEEEE, `cmd_ready` is 1, and `mem_we`, `mem_re`, `done` and `pc_load` are 0.
- R2: `cmd` bit 0 is PUSH. When it is accepted, in the next cycle `sp_out` is the old pointer minus 1, and `mem_we` is 1 with `mem_addr` equal to that new pointer and `mem_wdata` equal to `push_data`.
- R3: `cmd` bit 1 is POP. When it is accepted, in the next cycle `mem_re` is 1 with `mem_addr` equal to the old pointer, and `sp_out` is the old pointer plus 1. One cycle after that, `done` is 1 and `pop_data` holds the word stored at that address.
- R4: `cmd` bit 2 is CALL. It writes `pc_in` (the return address) to the old pointer minus 1, with the same timing and pointer change as PUSH. In its `done` cycle, `pc_load` is 1 and `pc_next` equals `call_target`.
- R5: `cmd` bit 3 is RET. It reads with the same timing and pointer change as POP. In its `done` cycle, `pc_load` is 1 and `pc_next` equals the popped word.
- R6: `cmd_ready` is 0 in the cycle after a command is accepted. A command presented in that cycle is ignored: it causes no memory access and no pointer change. A new command may be accepted in the `done` cycle.
- R7: A `cmd` value that does not have exactly one bit set is ignored. `cmd_ready` stays 1, no memory access is made, and `sp_out` is unchanged.
- R8: The stack pointer wraps modulo 2^16. A pop at 0xFFFF leaves 0x0000, and a push at 0x0000 leaves 0xFFFF.
- R9: `mem_we` and `mem_re` are never 1 together. `done` is 1 for exactly one cycle per accepted command, two cycles after the accepting edge.
- R10: PUSH and POP never assert `pc_load`, and `pc_load` is never 1 outside a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 4 | One-hot command: bit0 PUSH, bit1 POP, bit2 CALL, bit3 RET |
| cmd_ready | output | 1 | High when a command can be accepted |
| push_data | input | 16 | Word written by PUSH |
| pc_in | input | 16 | Return address saved by CALL |
| call_target | input | 16 | Program counter loaded by CALL |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write request |
| mem_re | output | 1 | Memory read request |
| mem_rdata | input | 16 | Memory read data, valid one cycle after `mem_re` |
| pop_data | output | 16 | Popped word, valid while `done` is high after POP or RET |
| pc_next | output | 16 | New program counter, valid while `pc_load` is high |
| pc_load | output | 1 | Program counter load strobe |
| sp_out | output | 16 | Current stack pointer |
| done | output | 1 | Command complete |

## Verification
The edge that accepts a command also updates `sp_out` and raises the memory request, so both are visible in the following cycle. `done`, `pc_load`, `pc_next` and `pop_data` become valid one cycle later, which is two cycles after acceptance. The bench keeps a reference model that steps through these same phases on every rising edge. It compares every output against the model at the following falling edge, so each value is checked exactly in the cycle where it is due. The directed checks for reset, pointer wrap and ignored commands are also taken on falling edges, after the edge that should or should not have changed the state.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam int unsigned N_OPS = 4;

  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } stk_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_REQ  = 1'b1
  } stk_state_e;

  function automatic logic op_writes(stk_op_e op);
    return (op == OP_PUSH) || (op == OP_CALL);
  endfunction

  function automatic logic op_loads_pc(stk_op_e op);
    return (op == OP_CALL) || (op == OP_RET);
  endfunction

endpackage

// File: rtl/stk_cmd_decode.sv
module stk_cmd_decode
  import stk_pkg::*;
#(
  parameter int unsigned NOPS = N_OPS
) (
  input  logic [NOPS-1:0] cmd,
  input  logic            ready,
  output logic            accept,
  output stk_op_e         op
);

  localparam int unsigned IW = $clog2(NOPS);

  logic [IW-1:0] enc;
  logic          one_hot;

  // Encode the set bit by OR-ing the command bits whose index has bit b set.
  for (genvar b = 0; b < IW; b++) begin : g_enc
    logic [NOPS-1:0] mask;
    always_comb begin
      mask = '0;
      for (int i = 0; i < NOPS; i++) begin
        mask[i] = ((i >> b) & 1) == 1;
      end
    end
    assign enc[b] = |(cmd & mask);
  end

  assign one_hot = (cmd != '0) && ((cmd & (cmd - NOPS'(1))) == '0);
  assign accept  = ready && one_hot;
  assign op      = stk_op_e'(enc);

endmodule

// File: rtl/stk_pointer.sv
module stk_pointer #(
  parameter int unsigned   AW       = 16,
  parameter logic [AW-1:0] RESET_SP = 16'hEEEE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_en,
  input  logic          inc_en,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] sp_dec
);

  logic [AW-1:0] sp_inc;

  assign sp_dec = sp - AW'(1);
  assign sp_inc = sp + AW'(1);

  // Natural modulo-2^AW arithmetic gives the wrap at both ends.
  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= RESET_SP;
    end else if (dec_en) begin
      sp <= sp_dec;
    end else if (inc_en) begin
      sp <= sp_inc;
    end
  end

endmodule

// File: rtl/stk_sequencer.sv
module stk_sequencer
  import stk_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  stk_op_e       op,
  input  logic [DW-1:0] push_data,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] call_target,
  input  logic [AW-1:0] sp,
  input  logic [AW-1:0] sp_dec,
  input  logic [DW-1:0] mem_rdata,
  output logic          ready,
  output logic          sp_dec_en,
  output logic          sp_inc_en,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          done,
  output logic          pc_load,
  output logic [AW-1:0] pc_next,
  output logic [DW-1:0] pop_data
);

  stk_state_e    state;
  stk_op_e       op_q;
  logic [AW-1:0] target_q;

  assign ready     = (state == ST_IDLE);
  assign sp_dec_en = accept && op_writes(op);
  assign sp_inc_en = accept && !op_writes(op);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= OP_PUSH;
      target_q  <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      done      <= 1'b0;
      pc_load   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          done    <= 1'b0;
          pc_load <= 1'b0;
          if (accept) begin
            state    <= ST_REQ;
            op_q     <= op;
            target_q <= call_target;
            if (op_writes(op)) begin
              mem_we    <= 1'b1;
              mem_addr  <= sp_dec;
              mem_wdata <= (op == OP_PUSH) ? push_data : DW'(pc_in);
            end else begin
              mem_re   <= 1'b1;
              mem_addr <= sp;
            end
          end
        end
        ST_REQ: begin
          state   <= ST_IDLE;
          mem_we  <= 1'b0;
          mem_re  <= 1'b0;
          done    <= 1'b1;
          pc_load <= op_loads_pc(op_q);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Memory output is already a register; forward it in the done cycle.
  assign pop_data = mem_rdata;
  assign pc_next  = (op_q == OP_RET) ? mem_rdata[AW-1:0] : target_q;

endmodule

// File: rtl/stack_call_unit.sv
module stack_call_unit
  import stk_pkg::*;
#(
  parameter int unsigned   AW       = 16,
  parameter int unsigned   DW       = 16,
  parameter logic [AW-1:0] RESET_SP = 16'hEEEE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_OPS-1:0] cmd,
  output logic             cmd_ready,
  input  logic [DW-1:0]    push_data,
  input  logic [AW-1:0]    pc_in,
  input  logic [AW-1:0]    call_target,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             mem_we,
  output logic             mem_re,
  input  logic [DW-1:0]    mem_rdata,
  output logic [DW-1:0]    pop_data,
  output logic [AW-1:0]    pc_next,
  output logic             pc_load,
  output logic [AW-1:0]    sp_out,
  output logic             done
);

  logic          accept;
  stk_op_e       op;
  logic          dec_en;
  logic          inc_en;
  logic [AW-1:0] sp_dec;

  stk_cmd_decode #(.NOPS(N_OPS)) i_decode (
    .cmd    (cmd),
    .ready  (cmd_ready),
    .accept (accept),
    .op     (op)
  );

  stk_pointer #(.AW(AW), .RESET_SP(RESET_SP)) i_pointer (
    .clk    (clk),
    .rst    (rst),
    .dec_en (dec_en),
    .inc_en (inc_en),
    .sp     (sp_out),
    .sp_dec (sp_dec)
  );

  stk_sequencer #(.AW(AW), .DW(DW)) i_seq (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .op          (op),
    .push_data   (push_data),
    .pc_in       (pc_in),
    .call_target (call_target),
    .sp          (sp_out),
    .sp_dec      (sp_dec),
    .mem_rdata   (mem_rdata),
    .ready       (cmd_ready),
    .sp_dec_en   (dec_en),
    .sp_inc_en   (inc_en),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .done        (done),
    .pc_load     (pc_load),
    .pc_next     (pc_next),
    .pop_data    (pop_data)
  );

endmodule

// File: rtl/stack_call_unit_chk.sv
module stack_call_unit_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    cmd,
  input logic          cmd_ready,
  input logic          mem_we,
  input logic          mem_re,
  input logic          done,
  input logic          pc_load,
  input logic [AW-1:0] sp_out
);

  p_rw_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_load_in_done_r10: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> done);

  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready && $onehot(cmd)) |=> !cmd_ready);

  p_held_off_r6: assert property (@(posedge clk) disable iff (rst)
    !cmd_ready |=> $stable(sp_out));

  p_push_dec_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready && cmd == 4'b0001) |=> (mem_we && sp_out == $past(sp_out) - AW'(1)));

  p_pop_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready && cmd == 4'b0010) |=> (mem_re && sp_out == $past(sp_out) + AW'(1)));

  p_call_dec_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready && cmd == 4'b0100) |=> (mem_we && sp_out == $past(sp_out) - AW'(1)));

  p_ret_inc_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready && cmd == 4'b1000) |=> (mem_re && sp_out == $past(sp_out) + AW'(1)));

  p_bad_cmd_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready && !$onehot(cmd)) |=> ($stable(sp_out) && !mem_we && !mem_re));

endmodule

bind stack_call_unit stack_call_unit_chk #(.AW(AW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd       (cmd),
  .cmd_ready (cmd_ready),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .done      (done),
  .pc_load   (pc_load),
  .sp_out    (sp_out)
);

// File: tb/test_stack_call_unit.sv
module test_stack_call_unit;

  localparam time CLK_PERIOD = 10;

  int checks = 0;
  int errors = 0;
  string g_tag = "R1";
  bit cmp_on = 0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cmd = 4'b0;
  logic        cmd_ready;
  logic [15:0] push_data = '0;
  logic [15:0] pc_in = '0;
  logic [15:0] call_target = '0;
  logic [15:0] mem_addr, mem_wdata, pop_data, pc_next, sp_out;
  logic        mem_we, mem_re, pc_load, done;
  logic [15:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_call_unit i_stack_call_unit (
    .clk(clk), .rst(rst), .cmd(cmd), .cmd_ready(cmd_ready),
    .push_data(push_data), .pc_in(pc_in), .call_target(call_target),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .pop_data(pop_data), .pc_next(pc_next),
    .pc_load(pc_load), .sp_out(sp_out), .done(done)
  );

  // Bench memory: one-cycle read latency.
  int bmem [int];
  always @(posedge clk) begin
    if (mem_we) bmem[int'(mem_addr)] = int'(mem_wdata);
    if (mem_re) mem_rdata <= bmem.exists(int'(mem_addr)) ? 16'(bmem[int'(mem_addr)]) : 16'h0;
  end

  // Behavioural reference model.
  int rmem [int];
  int m_sp, m_op, m_addr, m_wdata, m_pc, m_pop, m_target;
  bit m_busy, m_we, m_re, m_done, m_load;

  always @(posedge clk) begin
    if (rst) begin
      m_sp = 'hEEEE; m_busy = 0; m_we = 0; m_re = 0; m_done = 0; m_load = 0;
      m_op = 0; m_addr = 0; m_wdata = 0; m_pc = 0; m_pop = 0; m_target = 0;
    end else if (m_busy) begin
      m_busy = 0; m_we = 0; m_re = 0; m_done = 1;
      if (m_op == 0 || m_op == 2) rmem[m_addr] = m_wdata;
      else m_pop = rmem.exists(m_addr) ? rmem[m_addr] : 0;
      m_load = (m_op >= 2);
      m_pc = (m_op == 3) ? m_pop : m_target;
    end else begin
      m_done = 0; m_load = 0;
      if (cmd == 4'b0001 || cmd == 4'b0010 || cmd == 4'b0100 || cmd == 4'b1000) begin
        m_op = (cmd == 4'b0001) ? 0 : (cmd == 4'b0010) ? 1 : (cmd == 4'b0100) ? 2 : 3;
        m_busy = 1;
        m_target = int'(call_target);
        if (m_op == 0 || m_op == 2) begin
          m_sp = (m_sp - 1) & 'hFFFF;
          m_addr = m_sp; m_we = 1;
          m_wdata = (m_op == 0) ? int'(push_data) : int'(pc_in);
        end else begin
          m_addr = m_sp; m_re = 1;
          m_sp = (m_sp + 1) & 'hFFFF;
        end
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk(g_tag, "sp_out", int'(sp_out), m_sp);
      chk("R6", "cmd_ready", int'(cmd_ready), int'(!m_busy));
      chk(g_tag, "mem_we", int'(mem_we), int'(m_we));
      chk("R9", "mem_re", int'(mem_re), int'(m_re));
      if (m_we || m_re) chk(g_tag, "mem_addr", int'(mem_addr), m_addr);
      if (m_we) chk(g_tag, "mem_wdata", int'(mem_wdata), m_wdata);
      chk("R9", "done", int'(done), int'(m_done));
      chk((m_op < 2) ? "R10" : g_tag, "pc_load", int'(pc_load), int'(m_load));
      if (m_load) chk(g_tag, "pc_next", int'(pc_next), m_pc);
      if (m_done && (m_op == 1 || m_op == 3)) chk(g_tag, "pop_data", int'(pop_data), m_pop);
    end
  end

  // Wait for ready at a falling edge, present a command for one cycle.
  task automatic send(logic [3:0] c, logic [15:0] d, logic [15:0] p, logic [15:0] t);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd = c; push_data = d; pc_in = p; call_target = t;
    @(negedge clk);
    cmd = 4'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R9 watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    chk("R1", "sp_out", int'(sp_out), 'hEEEE);
    chk("R1", "cmd_ready", int'(cmd_ready), 1);
    chk("R1", "mem_we", int'(mem_we), 0);
    chk("R1", "mem_re", int'(mem_re), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "pc_load", int'(pc_load), 0);
    rst = 1'b0;
    cmp_on = 1;
    @(negedge clk);
    chk("R1", "sp_out after release", int'(sp_out), 'hEEEE);

    g_tag = "R2"; send(4'b0001, 16'hA5A5, 16'h0, 16'h0);
    chk("R2", "sp after push", int'(sp_out), 'hEEED);
    send(4'b0001, 16'h1234, 16'h0, 16'h0);
    g_tag = "R3"; send(4'b0010, 16'h0, 16'h0, 16'h0);
    g_tag = "R4"; send(4'b0100, 16'h0, 16'h0123, 16'h0400);
    g_tag = "R5"; send(4'b1000, 16'h0, 16'h0, 16'h0);
    g_tag = "R3"; send(4'b0010, 16'h0, 16'h0, 16'h0);
    repeat (2) @(negedge clk);
    chk("R3", "sp balanced", int'(sp_out), 'hEEEE);

    // R6: command in the busy cycle is ignored
    g_tag = "R6";
    send(4'b0001, 16'h7777, 16'h0, 16'h0);
    cmd = 4'b0010;
    @(negedge clk);
    cmd = 4'b0;
    repeat (2) @(negedge clk);
    chk("R6", "sp after held-off pop", int'(sp_out), 'hEEED);

    // R7: not one-hot
    g_tag = "R7";
    cmd = 4'b0011; @(negedge clk);
    cmd = 4'b1111; @(negedge clk);
    cmd = 4'b0110; @(negedge clk);
    cmd = 4'b0;    @(negedge clk);
    chk("R7", "sp after bad cmds", int'(sp_out), 'hEEED);

    // Back-to-back: held push accepted every other cycle
    g_tag = "R2";
    push_data = 16'hBEEF;
    cmd = 4'b0001;
    repeat (6) @(negedge clk);
    cmd = 4'b0;
    repeat (2) @(negedge clk);
    chk("R6", "sp after held push", int'(sp_out), 'hEEEA);

    // R8: wrap upward, then downward
    g_tag = "R8";
    for (int n = 0; n < 5000 && sp_out != 16'hFFFF; n++) send(4'b0010, 16'h0, 16'h0, 16'h0);
    chk("R8", "sp reached top", int'(sp_out), 'hFFFF);
    send(4'b0010, 16'h0, 16'h0, 16'h0);
    chk("R8", "sp wrap up", int'(sp_out), 'h0000);
    repeat (2) @(negedge clk);
    send(4'b0100, 16'h0, 16'h0F0F, 16'h2222);
    chk("R8", "sp wrap down", int'(sp_out), 'hFFFF);
    g_tag = "R5";
    send(4'b1000, 16'h0, 16'h0, 16'h0);
    repeat (3) @(negedge clk);
    chk("R5", "sp after ret", int'(sp_out), 'h0000);

    finish_run();
  end

endmodule